// File: doc/BRIEF.md
# Serial Converter Access Master

This block is the host-side master for a 10-bit serial analog-to-digital converter. The converter is reached over a chip select, an I/O clock, a serial address line and a serial data line. The host hands the block a 4-bit channel number on a valid/ready request port. The block then runs one complete access, which has five parts:

- It lowers chip select and waits out a setup delay.
- It issues exactly ten I/O clock pulses.
- On the first four pulses it shifts out the channel number, most significant bit first.
- At the same time it collects the ten result bits the converter returns.
- It raises chip select and waits out the conversion time before it takes the next request.

The converter always returns the result of the conversion started by the access before. The response port therefore tags each word with the channel of the previous request. The first word after reset is marked stale, because no conversion was requested before it.

The request side applies back-pressure. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_chan` is captured at that edge and ignored for the rest of the access. The response side has no back-pressure: `rsp_valid` is a single-cycle strobe, and the host must take the word in that cycle.

All timing is counted in host clock cycles. The block assumes the host clock runs no faster than the converter's system clock, so that cycle counts stated in converter clocks still hold. `CLK_DIV` sets the length of each I/O clock phase. Pick it so that each phase lasts at least about 404 ns and the I/O clock stays at or below 1.1 MHz.

Top module: `sadc_host`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 0, `adc_addr` is 0, `rsp_valid` is 0 and `req_ready` is 1, and nothing changes until a request arrives.
- R2: `req_ready` is 1 only while idle. It is 0 from the edge that accepts a request until the conversion wait ends, and `adc_cs_n` is 0 only while `req_ready` is 0. Without `req_valid` no access starts. `req_chan` changes while busy do not alter the running access.
- R3: `adc_cs_n` is low for exactly max(`CS_SETUP`, `CLK_DIV`) cycles before the first rising edge of `adc_sclk` (3 with defaults).
- R4: Each access has exactly ten `adc_sclk` pulses. Every high phase and every low phase between pulses lasts exactly `CLK_DIV` cycles.
- R5: The channel is sent most significant bit first. The bit sampled on rising edge k (k = 1..4) is bit 4-k of the accepted channel. `adc_addr` only changes with a falling edge or with the accepting edge, never while `adc_sclk` is high. It is 0 for rising edges 5 to 10.
- R6: The data bit on `adc_dout` is sampled on each rising edge of `adc_sclk`. The first sample takes the bit present since chip select fell. The ten samples form `rsp_data` with the first sample as bit 9.
- R7: `rsp_valid` is a one-cycle pulse, issued on the edge of the tenth falling `adc_sclk` edge. That same edge raises `adc_cs_n`.
- R8: `rsp_chan` is the channel of the request accepted one access earlier, or 0 for the first access. `rsp_stale` is 1 on the first response after reset and 0 on every later one.
- R9: After the tenth falling edge, `adc_cs_n` stays high and `req_ready` returns to 1 exactly `CONV_CYC` cycles after `adc_cs_n` rose. Chip select therefore falls again no sooner than `CONV_CYC`+1 cycles after it rose.
- R10: `adc_sclk` is 0 whenever `adc_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_chan | input | 4 | Channel number to convert next |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 10 | Received result word |
| rsp_chan | output | 4 | Channel the result belongs to |
| rsp_stale | output | 1 | Result carries no real conversion |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter I/O clock |
| adc_addr | output | 1 | Serial channel address to converter |
| adc_dout | input | 1 | Serial result bit from converter |

## Verification
With default parameters, an access accepted on edge A has these timings:

- Chip select falls on edge A.
- The first I/O clock rise follows 3 edges later.
- After that, `adc_sclk` toggles every 2 edges.
- The result strobe coincides with the tenth fall, 3 + 19·2 edges after A.
- `req_ready` reappears 44 edges after that strobe.

The bench contains a behavioural converter model that acts only at falling clock edges. It compares each port against these counts in the half-cycle after the edge that should have moved it. That model also drives the next result bit in the half-cycle after each I/O clock fall, so the design's sampling edge lies a full `CLK_DIV` cycles later.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_CONV
  } sadc_state_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sadc_phase_timer.sv
module sadc_phase_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R4: a loaded count only ever decreases by one per cycle
  a_r4_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sadc_addr_ser.sv
module sadc_addr_ser #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] chan,
  input  logic              shift,
  output logic              bit_o
);

  logic [ADDR_W-1:0] sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sreg_q <= '0;
    else if (load)   sreg_q <= chan;
    else if (shift)  sreg_q <= {sreg_q[ADDR_W-2:0], 1'b0};
  end

  assign bit_o = sreg_q[ADDR_W-1];

  // R5: the serial line moves only on a load or a shift
  a_r5_addr_moves_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(shift)) |-> $stable(bit_o));

endmodule

// File: rtl/sadc_rx_shift.sv
module sadc_rx_shift #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              din,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (sample)  sh_q <= {sh_q[DATA_W-2:0], din};
  end

  assign word = sh_q;

  // R6: the newest sample lands in bit 0
  a_r6_sample_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sample) |-> (sh_q[0] == $past(din)));

endmodule

// File: rtl/sadc_rsp_tag.sv
module sadc_rsp_tag #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] chan,
  input  logic              done,
  input  logic [DATA_W-1:0] word,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rsp_chan,
  output logic              rsp_stale
);

  logic [ADDR_W-1:0] cur_q, prev_q;
  logic              first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= '0;
      prev_q    <= '0;
      first_q   <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_chan  <= '0;
      rsp_stale <= 1'b0;
    end else begin
      rsp_valid <= done;
      if (accept) cur_q <= chan;
      if (done) begin
        rsp_data  <= word;
        rsp_chan  <= prev_q;
        rsp_stale <= first_q;
        prev_q    <= cur_q;
        first_q   <= 1'b0;
      end
    end
  end

  // R7: the strobe never lasts two cycles
  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: once a response has been issued, later ones are never stale
  a_r8_stale_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !first_q && !$past(first_q)) |-> !rsp_stale);

endmodule

// File: rtl/sadc_host.sv
module sadc_host #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 10,
  parameter int N_PULSE  = 10,
  parameter int CLK_DIV  = 2,
  parameter int CS_SETUP = 3,
  parameter int CONV_CYC = 44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_chan,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rsp_chan,
  output logic              rsp_stale,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              adc_addr,
  input  logic              adc_dout
);
  import sadc_pkg::*;

  localparam int SETUP_LEN = imax(CS_SETUP, CLK_DIV);
  localparam int MAX_CNT   = imax(imax(SETUP_LEN, CLK_DIV), CONV_CYC + 1);
  localparam int TW        = $clog2(MAX_CNT + 1);
  localparam int PW        = $clog2(N_PULSE + 1);
  localparam int HW        = $clog2(CONV_CYC + 2);

  sadc_state_e   state_q, state_d;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          accept, rise, fall, last;
  logic [PW-1:0] pulse_q;
  logic          cs_n_q, sclk_q;
  logic [DATA_W-1:0] rx_word;

  // sequencing of one access
  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    accept  = 1'b0;
    rise    = 1'b0;
    fall    = 1'b0;
    last    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_SETUP;
          t_load  = 1'b1;
          t_val   = TW'(SETUP_LEN - 1);
        end
      end
      ST_SETUP, ST_LOW: begin
        if (t_zero) begin
          rise    = 1'b1;
          state_d = ST_HIGH;
          t_load  = 1'b1;
          t_val   = TW'(CLK_DIV - 1);
        end
      end
      ST_HIGH: begin
        if (t_zero) begin
          fall   = 1'b1;
          t_load = 1'b1;
          if (pulse_q == PW'(N_PULSE - 1)) begin
            last    = 1'b1;
            state_d = ST_CONV;
            t_val   = TW'(CONV_CYC - 1);
          end else begin
            state_d = ST_LOW;
            t_val   = TW'(CLK_DIV - 1);
          end
        end
      end
      ST_CONV: begin
        if (t_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept)    pulse_q <= '0;
      else if (fall) pulse_q <= pulse_q + 1'b1;
      if (accept)    cs_n_q  <= 1'b0;
      else if (last) cs_n_q  <= 1'b1;
      if (rise)      sclk_q  <= 1'b1;
      else if (fall) sclk_q  <= 1'b0;
    end
  end

  sadc_phase_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  sadc_addr_ser #(.ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .chan  (req_chan),
    .shift (fall),
    .bit_o (adc_addr)
  );

  sadc_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (rise),
    .din    (adc_dout),
    .word   (rx_word)
  );

  sadc_rsp_tag #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tag (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .chan      (req_chan),
    .done      (last),
    .word      (rx_word),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_chan  (rsp_chan),
    .rsp_stale (rsp_stale)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign adc_cs_n  = cs_n_q;
  assign adc_sclk  = sclk_q;

  // window counters used only by the checks below
  logic [TW-1:0] hi_len_q, lo_len_q;
  logic [HW-1:0] cs_hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len_q <= '0;
      lo_len_q <= '0;
      cs_hi_q  <= HW'(CONV_CYC + 1);
    end else begin
      hi_len_q <= sclk_q ? hi_len_q + 1'b1 : '0;
      if (cs_n_q || sclk_q)          lo_len_q <= '0;
      else if (lo_len_q != '1)       lo_len_q <= lo_len_q + 1'b1;
      if (!cs_n_q)                   cs_hi_q  <= '0;
      else if (cs_hi_q != HW'(CONV_CYC + 1)) cs_hi_q <= cs_hi_q + 1'b1;
    end
  end

  a_r10_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

  a_r5_addr_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> $stable(adc_addr));

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> !req_ready);

  a_r4_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sclk) |-> (hi_len_q == TW'(CLK_DIV)));

  a_r3_setup_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adc_sclk) && pulse_q == '0) |-> (lo_len_q == TW'(SETUP_LEN)));

  a_r7_strobe_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(adc_cs_n));

  a_r9_conv_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> (cs_hi_q == HW'(CONV_CYC + 1)));

endmodule

// File: tb/sadc_host_tb.sv
module sadc_host_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 2;
  localparam int CS_SETUP   = 3;
  localparam int CONV_CYC   = 44;
  localparam int SETUP_LEN  = (CS_SETUP > CLK_DIV) ? CS_SETUP : CLK_DIV;
  localparam int N_ACC      = 36;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_chan = 4'd0;
  logic       rsp_valid;
  logic [9:0] rsp_data;
  logic [3:0] rsp_chan;
  logic       rsp_stale;
  logic       adc_cs_n, adc_sclk, adc_addr;
  logic       adc_dout = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadc_host #(
    .CLK_DIV  (CLK_DIV),
    .CS_SETUP (CS_SETUP),
    .CONV_CYC (CONV_CYC)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_chan  (req_chan),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_chan  (rsp_chan),
    .rsp_stale (rsp_stale),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .adc_addr  (adc_addr),
    .adc_dout  (adc_dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] chan_of(input int i);
    return 4'((i * 5 + 3) % 16);
  endfunction

  function automatic logic [9:0] word_of(input logic [3:0] ch, input int n);
    if (n == 3) return 10'h3FF;
    if (n == 4) return 10'h000;
    return 10'((int'(ch) * 61 + n * 23 + 5) % 1024);
  endfunction

  // behavioural converter and port monitor, acting at falling clock edges
  logic       p_cs = 1'b1, p_sclk = 1'b0;
  logic [9:0] m_stored = 10'd0, m_out = 10'd0, cur_word = 10'd0;
  logic [3:0] m_addr = 4'd0, prev_chan = 4'd0;
  int m_rise = 0, m_fall = 0, n_acc = 0;
  int setup_cnt = 0, hi_len = 0, lo_len = 0, cs_hi = 0, gapc = 0;
  bit armed = 1'b0, tenth = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tenth = 1'b0;
      if (adc_cs_n && adc_sclk) chk(1'b0, "R10 sclk high with cs high", 1, 0);
      if (!adc_cs_n && req_ready) chk(1'b0, "R2 ready while busy", 1, 0);

      if (p_cs && !adc_cs_n) begin
        if (n_acc > 0) chk(cs_hi >= CONV_CYC + 1, "R9 cs high gap", cs_hi, CONV_CYC + 1);
        m_out = m_stored; cur_word = m_stored;
        adc_dout = m_stored[9];
        m_rise = 0; m_fall = 0; m_addr = 4'd0; setup_cnt = 0;
      end
      if (!p_cs && adc_cs_n) begin
        gapc = 1; armed = 1'b1; cs_hi = 1;
      end else if (adc_cs_n) begin
        cs_hi++;
        if (armed && !req_ready) gapc++;
        else if (armed && req_ready) begin
          chk(gapc == CONV_CYC, "R9 ready return", gapc, CONV_CYC);
          armed = 1'b0;
        end
      end

      if (!p_sclk && adc_sclk) begin
        if (m_rise == 0) chk(setup_cnt == SETUP_LEN, "R3 cs setup", setup_cnt, SETUP_LEN);
        else chk(lo_len == CLK_DIV, "R4 low phase", lo_len, CLK_DIV);
        if (m_rise < 4) m_addr = {m_addr[2:0], adc_addr};
        else chk(adc_addr == 1'b0, "R5 addr idle after four", adc_addr, 0);
        m_rise++;
        hi_len = 1;
      end else if (p_sclk && !adc_sclk) begin
        chk(hi_len == CLK_DIV, "R4 high phase", hi_len, CLK_DIV);
        m_fall++;
        lo_len = 1;
        if (m_fall < 10) begin
          m_out = {m_out[8:0], 1'b0};
          adc_dout = m_out[9];
        end else begin
          tenth = 1'b1;
          chk(m_rise == 10, "R4 ten pulses", m_rise, 10);
          chk(adc_cs_n == 1'b1, "R7 cs up at tenth fall", adc_cs_n, 1);
          chk(m_addr == chan_of(n_acc), "R5 address", m_addr, chan_of(n_acc));
          chk(rsp_valid == 1'b1, "R7 strobe", rsp_valid, 1);
          chk(rsp_data == cur_word, "R6 data", rsp_data, cur_word);
          chk(rsp_chan == prev_chan, "R8 channel tag", rsp_chan, prev_chan);
          chk(rsp_stale == (n_acc == 0), "R8 stale flag", rsp_stale, n_acc == 0);
          m_stored = word_of(m_addr, n_acc);
          prev_chan = m_addr;
          n_acc++;
        end
      end else begin
        if (adc_sclk) hi_len++; else lo_len++;
        if (!adc_cs_n && !adc_sclk && m_rise == 0) setup_cnt++;
      end
      if (p_cs && !adc_cs_n && !adc_sclk) setup_cnt = 1;
      if (rsp_valid && !tenth) chk(1'b0, "R7 stray strobe", 1, 0);
      p_cs = adc_cs_n;
      p_sclk = adc_sclk;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 cs reset", adc_cs_n, 1);
    chk(adc_sclk == 1'b0, "R1 sclk reset", adc_sclk, 0);
    chk(adc_addr == 1'b0, "R1 addr reset", adc_addr, 0);
    chk(rsp_valid == 1'b0, "R1 valid reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready idle", req_ready, 1);
    chk(adc_cs_n == 1'b1, "R2 no access without valid", adc_cs_n, 1);
    for (int i = 0; i < N_ACC; i++) begin
      req_chan  = chan_of(i);
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      chk(adc_cs_n == 1'b0 && req_ready == 1'b0, "R2 accept", {adc_cs_n, req_ready}, 0);
      if (i % 6 == 5) begin
        req_valid = 1'b0;
        repeat (100) @(negedge clk);
        chk(adc_cs_n == 1'b1 && req_ready == 1'b1, "R2 idle without valid",
            {adc_cs_n, req_ready}, 3);
      end else begin
        req_chan = ~chan_of(i);
      end
    end
    req_valid = 1'b0;
    repeat (100) @(negedge clk);
    chk(n_acc == N_ACC, "R7 response count", n_acc, N_ACC);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", n_acc, N_ACC);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule